// File: doc/BRIEF.md
# Register-Tagged Vector Issue Expander

This block sits between instruction decode and a scalar execute stage. It holds a small associative table of register tags. Each tag names a scalar register as a vector key. It gives a base register for that vector, a numeric type (integer or floating point) and an element width code. When a decoded instruction names a tagged register as an operand, the block unrolls it into a run of scalar micro-operations. The run has one micro-op per cycle, and each micro-op steps the tagged operands through consecutive registers. An operand that is not tagged stays the same in every micro-op, so it acts as a broadcast scalar. An instruction with no tagged operand passes through as a single micro-op.

The block also executes the set-vector-length operation. That operation takes the smaller of a requested maximum and a remaining element count, stores it as the current vector length, and reports it in a micro-op that targets the instruction's destination register. While an expansion runs, the block stalls decode through its ready signal. Table writes may arrive at any time. Each instruction captures the tag lookups at the moment it is accepted.

Top module: `tagvec_expander`

## Requirements
- R1: An instruction with no tagged operand is issued as exactly one micro-op in the cycle after acceptance. That micro-op carries the same opcode and register numbers, element index 0, type bit 0 and width code 0.
- R2: A register that matches the key of a valid table entry is replaced by that entry's value register as a base. Micro-op k (k = 0 .. count-1) uses base+k for that operand and reports k on the element index output.
- R3: An operand without a matching entry keeps its register number unchanged in every micro-op of a run.
- R4: When several valid entries match the same key, the entry with the lowest index supplies the base, type and width.
- R5: The set-vector-length operation sets the vector length to min(requested maximum, remaining count). It issues one micro-op flagged as set-vector-length, with the instruction's destination register and the new length on the length output. Its registers are never looked up in the table.
- R6: While the vector length is 0, an instruction with a tagged operand issues no micro-op and leaves the block ready. An instruction without a tagged operand still issues one micro-op.
- R7: Ready is low from the cycle after acceptance until the last micro-op of the run has been issued. An instruction presented while ready is low is ignored.
- R8: A table write made during a run does not change the remaining micro-ops of that run. It applies from the next accepted instruction onwards.
- R9: If base+k would pass register 31 for any tagged operand, the run stops at register 31. Every micro-op of such a truncated run has the overflow output high.
- R10: The type bit and width code of a micro-op come from the entry of the first tagged operand, checked in the order destination, first source, second source. Width code 0 means the register's native width, and codes 1, 2 and 3 mean 8, 16 and 32 bits.
- R11: After reset the table holds no valid entry, no micro-op is issued, ready is high and the vector length equals VL_RESET (1 by default).
- R12: An entry written with its valid bit at 0 matches no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | IDX_W | Entry index to write |
| tw_valid | input | 1 | Valid bit of the written entry |
| tw_key | input | 5 | Key register of the written entry |
| tw_val | input | 5 | Base register of the written entry |
| tw_fp | input | 1 | Type bit of the written entry: 1 floating point, 0 integer |
| tw_ew | input | 2 | Width code of the written entry (0 native) |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Block can accept an instruction |
| in_op | input | OP_W | Opcode carried through to micro-ops |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_setvl | input | 1 | Instruction is set-vector-length |
| in_avl | input | AVL_W | Remaining element count for set-vector-length |
| in_maxvl | input | VL_W | Requested maximum length for set-vector-length |
| uop_valid | output | 1 | Micro-op valid |
| uop_op | output | OP_W | Micro-op opcode |
| uop_rd | output | 5 | Micro-op destination register |
| uop_rs1 | output | 5 | Micro-op first source register |
| uop_rs2 | output | 5 | Micro-op second source register |
| uop_idx | output | VL_W | Element index within the run |
| uop_fp | output | 1 | Type bit of the governing entry |
| uop_ew | output | 2 | Width code of the governing entry |
| uop_setvl | output | 1 | Micro-op is the result of set-vector-length |
| uop_vlval | output | VL_W | New vector length carried by that micro-op |
| uop_ovf | output | 1 | Run was truncated at register 31 |
| vl_o | output | VL_W | Current vector length |

## Verification
A corrupted lookup shows up at once. The first micro-op after acceptance carries the wrong base, type or width, or carries a tagged register unchanged. A wrong element counter or vector length shows up as a run that is too short or too long. This appears within at most one vector length of cycles, either as a bad register number on the last micro-op or as ready returning early or late. Stale or premature table state appears only on the instruction that follows a mid-run write. For that reason the bench checks both the run that was interrupted and the next run.

// File: rtl/tagvec_pkg.sv
package tagvec_pkg;

  localparam int REG_W = 5;
  localparam int EW_W  = 2;

  localparam logic [EW_W-1:0] EW_NATIVE = 2'd0;
  localparam logic [EW_W-1:0] EW_8      = 2'd1;
  localparam logic [EW_W-1:0] EW_16     = 2'd2;
  localparam logic [EW_W-1:0] EW_32     = 2'd3;

  typedef struct packed {
    logic             valid;
    logic             fp;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] val;
    logic [EW_W-1:0]  ew;
  } tag_entry_t;

  typedef struct packed {
    logic             hit;
    logic             fp;
    logic [REG_W-1:0] base;
    logic [EW_W-1:0]  ew;
  } tag_hit_t;

endpackage

// File: rtl/tagvec_match.sv
module tagvec_match
  import tagvec_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  tag_entry_t [ENTRIES-1:0] ents,
  input  logic [REG_W-1:0]         key,
  output tag_hit_t                 hit
);

  // Walk from the top index down so the lowest matching index is kept last.
  always_comb begin
    hit = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ents[i].valid && ents[i].key == key) begin
        hit.hit  = 1'b1;
        hit.fp   = ents[i].fp;
        hit.base = ents[i].val;
        hit.ew   = ents[i].ew;
      end
    end
  end

endmodule

// File: rtl/tagvec_table.sv
module tagvec_table
  import tagvec_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NPORT   = 3,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  tag_entry_t                  wr_ent,
  input  logic [NPORT-1:0][REG_W-1:0] q_key,
  output tag_hit_t [NPORT-1:0]        q_hit
);

  tag_entry_t [ENTRIES-1:0] ents;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else if (wr_en) begin
      ents[wr_idx] <= wr_ent;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tagvec_match #(.ENTRIES(ENTRIES)) u_match (
      .ents (ents),
      .key  (q_key[p]),
      .hit  (q_hit[p])
    );
  end

endmodule

// File: rtl/tagvec_seq.sv
module tagvec_seq #(
  parameter int VL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] count,
  output logic            busy,
  output logic [VL_W-1:0] idx,
  output logic            last
);

  logic [VL_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (start && count != '0) begin
      busy     <= 1'b1;
      idx      <= '0;
      last_idx <= count - 1'b1;
    end
  end

  assign last = busy && (idx == last_idx);

endmodule

// File: rtl/tagvec_expander.sv
module tagvec_expander
  import tagvec_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int OP_W     = 7,
  parameter int VL_W     = 6,
  parameter int AVL_W    = 32,
  parameter int VL_RESET = 1,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tw_en,
  input  logic [IDX_W-1:0] tw_idx,
  input  logic             tw_valid,
  input  logic [4:0]       tw_key,
  input  logic [4:0]       tw_val,
  input  logic             tw_fp,
  input  logic [1:0]       tw_ew,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [4:0]       in_rd,
  input  logic [4:0]       in_rs1,
  input  logic [4:0]       in_rs2,
  input  logic             in_setvl,
  input  logic [AVL_W-1:0] in_avl,
  input  logic [VL_W-1:0]  in_maxvl,
  output logic             uop_valid,
  output logic [OP_W-1:0]  uop_op,
  output logic [4:0]       uop_rd,
  output logic [4:0]       uop_rs1,
  output logic [4:0]       uop_rs2,
  output logic [VL_W-1:0]  uop_idx,
  output logic             uop_fp,
  output logic [1:0]       uop_ew,
  output logic             uop_setvl,
  output logic [VL_W-1:0]  uop_vlval,
  output logic             uop_ovf,
  output logic [VL_W-1:0]  vl_o
);

  localparam int NPORT = 3;

  // Registers remaining from base up to and including register 31.
  function automatic logic [VL_W-1:0] room_of(input logic [REG_W-1:0] b);
    return VL_W'(6'd32 - {1'b0, b});
  endfunction

  // New vector length: the smaller of the request and the remaining count.
  function automatic logic [VL_W-1:0] vl_pick(input logic [VL_W-1:0]  mx,
                                              input logic [AVL_W-1:0] avl);
    if (avl < AVL_W'(mx)) return avl[VL_W-1:0];
    return mx;
  endfunction

  // Register of element k; the run length keeps this at or below 31.
  function automatic logic [REG_W-1:0] elem_reg(input logic [REG_W-1:0] b,
                                                input logic [VL_W-1:0]  k);
    return b + k[REG_W-1:0];
  endfunction

  // Table write path
  tag_entry_t wr_ent;
  assign wr_ent.valid = tw_valid;
  assign wr_ent.fp    = tw_fp;
  assign wr_ent.key   = tw_key;
  assign wr_ent.val   = tw_val;
  assign wr_ent.ew    = tw_ew;

  logic [NPORT-1:0][REG_W-1:0] qkey;
  tag_hit_t [NPORT-1:0]        qhit;

  assign qkey[0] = in_rd;
  assign qkey[1] = in_rs1;
  assign qkey[2] = in_rs2;

  tagvec_table #(.ENTRIES(ENTRIES), .NPORT(NPORT), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tw_en),
    .wr_idx (tw_idx),
    .wr_ent (wr_ent),
    .q_key  (qkey),
    .q_hit  (qhit)
  );

  // Acceptance-time decisions
  logic                        acc_evt;
  logic                        zero_evt;
  logic                        last_evt;
  logic [NPORT-1:0]            tag_use;
  logic [VL_W-1:0]             count;
  logic                        ovf_nxt;
  logic                        fp_nxt;
  logic [EW_W-1:0]             ew_nxt;
  logic [VL_W-1:0]             vl_q;
  logic                        busy;
  logic [VL_W-1:0]             idx;

  assign in_ready = !busy;
  assign acc_evt  = in_valid && in_ready;

  for (genvar p = 0; p < NPORT; p++) begin : g_use
    assign tag_use[p] = qhit[p].hit && !in_setvl;
  end

  always_comb begin
    logic [VL_W-1:0] lim;
    lim     = vl_q;
    ovf_nxt = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (tag_use[p]) begin
        if (room_of(qhit[p].base) < lim) lim = room_of(qhit[p].base);
        if (room_of(qhit[p].base) < vl_q) ovf_nxt = 1'b1;
      end
    end
    if (in_setvl || tag_use == '0) begin
      count   = VL_W'(1);
      ovf_nxt = 1'b0;
    end else begin
      count = lim;
    end
  end

  // Type and width follow the first tagged operand: rd, then rs1, then rs2.
  always_comb begin
    fp_nxt = 1'b0;
    ew_nxt = EW_NATIVE;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (tag_use[p]) begin
        fp_nxt = qhit[p].fp;
        ew_nxt = qhit[p].ew;
      end
    end
  end

  assign zero_evt = acc_evt && (count == '0);

  // Context captured at acceptance; later table writes cannot reach it.
  logic [NPORT-1:0][REG_W-1:0] reg_q;
  logic [NPORT-1:0]            t_q;
  logic [OP_W-1:0]             op_q;
  logic                        fp_q;
  logic [EW_W-1:0]             ew_q;
  logic                        setvl_q;
  logic [VL_W-1:0]             vlval_q;
  logic                        ovf_q;
  logic [VL_W-1:0]             vl_new;

  assign vl_new = vl_pick(in_maxvl, in_avl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q   <= '0;
      t_q     <= '0;
      op_q    <= '0;
      fp_q    <= 1'b0;
      ew_q    <= EW_NATIVE;
      setvl_q <= 1'b0;
      vlval_q <= '0;
      ovf_q   <= 1'b0;
      vl_q    <= VL_W'(VL_RESET);
    end else if (acc_evt) begin
      for (int p = 0; p < NPORT; p++) begin
        reg_q[p] <= tag_use[p] ? qhit[p].base : qkey[p];
      end
      t_q     <= tag_use;
      op_q    <= in_op;
      fp_q    <= fp_nxt;
      ew_q    <= ew_nxt;
      setvl_q <= in_setvl;
      vlval_q <= vl_new;
      ovf_q   <= ovf_nxt;
      if (in_setvl) vl_q <= vl_new;
    end
  end

  tagvec_seq #(.VL_W(VL_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (acc_evt),
    .count (count),
    .busy  (busy),
    .idx   (idx),
    .last  (last_evt)
  );

  // Micro-op assembly
  logic [NPORT-1:0][REG_W-1:0] uop_reg;

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    assign uop_reg[p] = t_q[p] ? elem_reg(reg_q[p], idx) : reg_q[p];
  end

  assign uop_valid = busy;
  assign uop_op    = op_q;
  assign uop_rd    = uop_reg[0];
  assign uop_rs1   = uop_reg[1];
  assign uop_rs2   = uop_reg[2];
  assign uop_idx   = idx;
  assign uop_fp    = fp_q;
  assign uop_ew    = ew_q;
  assign uop_setvl = setvl_q;
  assign uop_vlval = vlval_q;
  assign uop_ovf   = busy && ovf_q;
  assign vl_o      = vl_q;

endmodule

// File: rtl/tagvec_checker.sv
module tagvec_checker #(
  parameter int VL_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_setvl,
  input logic [VL_W-1:0] in_maxvl,
  input logic            uop_valid,
  input logic [VL_W-1:0] uop_idx,
  input logic [4:0]      uop_rd,
  input logic [4:0]      uop_rs1,
  input logic [4:0]      uop_rs2,
  input logic            uop_ovf,
  input logic [VL_W-1:0] vl_o,
  input logic            acc_evt,
  input logic            zero_evt,
  input logic            last_evt,
  input logic [2:0]      t_q
);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !last_evt |=> uop_valid && (uop_idx == VL_W'($past(uop_idx) + 1'b1)));

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && !zero_evt |=> uop_valid && (uop_idx == '0));

  assert_bcast_rs1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !last_evt && !t_q[1] |=> $stable(uop_rs1));

  assert_bcast_rs2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !last_evt && !t_q[2] |=> $stable(uop_rs2));

  assert_ovf_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && uop_ovf |-> (t_q[0] && uop_rd == 5'd31) ||
                            (t_q[1] && uop_rs1 == 5'd31) ||
                            (t_q[2] && uop_rs2 == 5'd31));

  assert_vl_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && in_setvl |=> vl_o <= $past(in_maxvl));

  assert_zero_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !uop_valid);

endmodule

bind tagvec_expander tagvec_checker #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_setvl  (in_setvl),
  .in_maxvl  (in_maxvl),
  .uop_valid (uop_valid),
  .uop_idx   (uop_idx),
  .uop_rd    (uop_rd),
  .uop_rs1   (uop_rs1),
  .uop_rs2   (uop_rs2),
  .uop_ovf   (uop_ovf),
  .vl_o      (vl_o),
  .acc_evt   (acc_evt),
  .zero_evt  (zero_evt),
  .last_evt  (last_evt),
  .t_q       (t_q)
);

// File: tb/tb_tagvec_expander.sv
module tb_tagvec_expander;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_idx = '0;
  logic        tw_valid = 1'b0;
  logic [4:0]  tw_key = '0;
  logic [4:0]  tw_val = '0;
  logic        tw_fp = 1'b0;
  logic [1:0]  tw_ew = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_op = '0;
  logic [4:0]  in_rd = '0;
  logic [4:0]  in_rs1 = '0;
  logic [4:0]  in_rs2 = '0;
  logic        in_setvl = 1'b0;
  logic [31:0] in_avl = '0;
  logic [5:0]  in_maxvl = '0;
  logic        uop_valid;
  logic [6:0]  uop_op;
  logic [4:0]  uop_rd, uop_rs1, uop_rs2;
  logic [5:0]  uop_idx;
  logic        uop_fp;
  logic [1:0]  uop_ew;
  logic        uop_setvl;
  logic [5:0]  uop_vlval;
  logic        uop_ovf;
  logic [5:0]  vl_o;

  always #5 clk = ~clk;

  tagvec_expander dut (
    .clk(clk), .rst_n(rst_n),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_valid(tw_valid), .tw_key(tw_key),
    .tw_val(tw_val), .tw_fp(tw_fp), .tw_ew(tw_ew),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_rd(in_rd),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_setvl(in_setvl), .in_avl(in_avl),
    .in_maxvl(in_maxvl),
    .uop_valid(uop_valid), .uop_op(uop_op), .uop_rd(uop_rd), .uop_rs1(uop_rs1),
    .uop_rs2(uop_rs2), .uop_idx(uop_idx), .uop_fp(uop_fp), .uop_ew(uop_ew),
    .uop_setvl(uop_setvl), .uop_vlval(uop_vlval), .uop_ovf(uop_ovf), .vl_o(vl_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int n_got;
  int g_op[64], g_rd[64], g_rs1[64], g_rs2[64], g_idx[64];
  int g_fp[64], g_ew[64], g_ovf[64], g_sv[64], g_vlv[64];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic twrite(input int idx, input bit v, input int key, input int val,
                        input bit fp, input int ew);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 3'(idx); tw_valid = v; tw_key = 5'(key);
    tw_val = 5'(val); tw_fp = fp; tw_ew = 2'(ew);
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  // mid: 0 none, 1 present another instruction during the run,
  //      2 rewrite entry 1 (key 17 -> base 2) during the run
  task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                       input bit sv, input int avl, input int mx, input int mid);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1);
    in_rs2 = 5'(rs2); in_setvl = sv; in_avl = 32'(avl); in_maxvl = 6'(mx);
    @(posedge clk);
    n_got = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0; in_setvl = 1'b0; tw_en = 1'b0;
      if (uop_valid) begin
        g_op[n_got] = int'(uop_op);   g_rd[n_got]  = int'(uop_rd);
        g_rs1[n_got] = int'(uop_rs1); g_rs2[n_got] = int'(uop_rs2);
        g_idx[n_got] = int'(uop_idx); g_fp[n_got]  = int'(uop_fp);
        g_ew[n_got] = int'(uop_ew);   g_ovf[n_got] = int'(uop_ovf);
        g_sv[n_got] = int'(uop_setvl); g_vlv[n_got] = int'(uop_vlval);
        n_got++;
        if (n_got == 2 && mid == 1) begin
          in_valid = 1'b1; in_op = 7'h55; in_rd = 5'd1; in_rs1 = 5'd2; in_rs2 = 5'd3;
        end
        if (n_got == 2 && mid == 2) begin
          tw_en = 1'b1; tw_idx = 3'd1; tw_valid = 1'b1; tw_key = 5'd17;
          tw_val = 5'd2; tw_fp = 1'b0; tw_ew = 2'd1;
        end
      end
    end while (uop_valid && n_got < 64);
  endtask

  // {op, rd, rs1, rs2, expected micro-op count}
  localparam logic [23:0] PASS_VEC [4] = '{
    {7'h13, 5'd1,  5'd2,  5'd3,  2'd1},
    {7'h33, 5'd31, 5'd0,  5'd30, 2'd1},
    {7'h07, 5'd4,  5'd4,  5'd4,  2'd1},
    {7'h7f, 5'd0,  5'd17, 5'd13, 2'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11", "in_ready", int'(in_ready), 1);
    chk("R11", "uop_valid", int'(uop_valid), 0);
    chk("R11", "vl_o", int'(vl_o), 1);

    // R1 pass-through vectors with an empty table (also R11: no entry matches)
    for (int i = 0; i < 4; i++) begin
      issue(int'(PASS_VEC[i][23:17]), int'(PASS_VEC[i][16:12]), int'(PASS_VEC[i][11:7]),
            int'(PASS_VEC[i][6:2]), 1'b0, 0, 0, 0);
      chk("R1", "count", n_got, int'(PASS_VEC[i][1:0]));
      chk("R1", "op", g_op[0], int'(PASS_VEC[i][23:17]));
      chk("R1", "rd", g_rd[0], int'(PASS_VEC[i][16:12]));
      chk("R1", "rs1", g_rs1[0], int'(PASS_VEC[i][11:7]));
      chk("R1", "rs2", g_rs2[0], int'(PASS_VEC[i][6:2]));
      chk("R1", "idx", g_idx[0], 0);
      chk("R1", "fp/ew", g_fp[0] * 4 + g_ew[0], 0);
    end

    // R5 set vector length
    issue(7'h11, 5, 0, 0, 1'b1, 2, 4, 0);
    chk("R5", "count", n_got, 1);
    chk("R5", "setvl flag", g_sv[0], 1);
    chk("R5", "rd", g_rd[0], 5);
    chk("R5", "vlval avl<max", g_vlv[0], 2);
    chk("R5", "vl_o", int'(vl_o), 2);
    issue(7'h11, 6, 0, 0, 1'b1, 100, 4, 0);
    chk("R5", "vlval max<avl", g_vlv[0], 4);
    chk("R5", "vl_o", int'(vl_o), 4);

    // Table: 0 key13->13 int w32, 1 key17->17 fp w16, 2 key5->20,
    // 3 key6->24, 4 key6->8, 5 key9->30
    twrite(0, 1'b1, 13, 13, 1'b0, 3);
    twrite(1, 1'b1, 17, 17, 1'b1, 2);
    twrite(2, 1'b1, 5, 20, 1'b0, 0);
    twrite(3, 1'b1, 6, 24, 1'b0, 1);
    twrite(4, 1'b1, 6, 8, 1'b1, 3);
    twrite(5, 1'b1, 9, 30, 1'b0, 0);

    // R2 R3 R10: rd and rs1 tagged, rs2 broadcast
    issue(7'h21, 17, 13, 10, 1'b0, 0, 0, 0);
    chk("R2", "count", n_got, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2", "rd", g_rd[k], 17 + k);
      chk("R2", "rs1", g_rs1[k], 13 + k);
      chk("R2", "idx", g_idx[k], k);
      chk("R3", "rs2", g_rs2[k], 10);
      chk("R10", "fp", g_fp[k], 1);
      chk("R10", "ew", g_ew[k], 2);
    end

    // R2 redirection to a different base
    issue(7'h22, 1, 5, 2, 1'b0, 0, 0, 0);
    chk("R2", "count", n_got, 4);
    chk("R2", "rs1 first", g_rs1[0], 20);
    chk("R2", "rs1 last", g_rs1[3], 23);
    chk("R3", "rd", g_rd[3], 1);
    chk("R10", "ew native", g_ew[0], 0);

    // R4 overlap: entry 3 beats entry 4
    issue(7'h23, 1, 2, 6, 1'b0, 0, 0, 0);
    chk("R4", "rs2 first", g_rs2[0], 24);
    chk("R4", "rs2 last", g_rs2[3], 27);
    chk("R4", "fp", g_fp[0], 0);
    chk("R4", "ew", g_ew[0], 1);

    // R9 overflow: base 30, vl 4
    issue(7'h24, 1, 9, 2, 1'b0, 0, 0, 0);
    chk("R9", "count", n_got, 2);
    chk("R9", "rs1 first", g_rs1[0], 30);
    chk("R9", "rs1 last", g_rs1[1], 31);
    chk("R9", "ovf first", g_ovf[0], 1);
    chk("R9", "ovf last", g_ovf[1], 1);

    // R7 instruction presented mid-run is ignored
    issue(7'h25, 13, 1, 2, 1'b0, 0, 0, 1);
    chk("R7", "count", n_got, 4);
    chk("R7", "op of last", g_op[3], 7'h25);
    chk("R7", "rd of last", g_rd[3], 16);
    @(negedge clk);
    chk("R7", "no extra uop", int'(uop_valid), 0);
    chk("R7", "ready after run", int'(in_ready), 1);

    // R8 rewrite during a run
    issue(7'h26, 17, 1, 2, 1'b0, 0, 0, 2);
    chk("R8", "count", n_got, 4);
    chk("R8", "rd elem 2", g_rd[2], 19);
    chk("R8", "rd elem 3", g_rd[3], 20);
    chk("R8", "fp kept", g_fp[3], 1);
    issue(7'h26, 17, 3, 4, 1'b0, 0, 0, 0);
    chk("R8", "new base", g_rd[0], 2);
    chk("R8", "new last", g_rd[3], 5);
    chk("R8", "new ew", g_ew[0], 1);

    // R12 invalidated entry no longer matches
    twrite(1, 1'b0, 17, 2, 1'b0, 1);
    issue(7'h27, 17, 2, 3, 1'b0, 0, 0, 0);
    chk("R12", "count", n_got, 1);
    chk("R12", "rd", g_rd[0], 17);

    // R6 zero vector length
    issue(7'h11, 7, 0, 0, 1'b1, 0, 4, 0);
    chk("R6", "vl_o", int'(vl_o), 0);
    chk("R6", "vlval", g_vlv[0], 0);
    issue(7'h28, 13, 1, 2, 1'b0, 0, 0, 0);
    chk("R6", "tagged count", n_got, 0);
    chk("R6", "ready", int'(in_ready), 1);
    issue(7'h29, 1, 2, 3, 1'b0, 0, 0, 0);
    chk("R6", "untagged count", n_got, 1);
    chk("R6", "untagged rd", g_rd[0], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule